// File: doc/BRIEF.md
# Rate-Adaptive Parallel Sample Distributor

This block cuts a stream of samples into fixed-length segments and deals them out, one segment per lane, to a bank of identical parallel processing lanes. Only the lowest-indexed lanes that the current bandwidth level allows are in the rotation. The lanes that are not in use have their power-enable outputs dropped. After the lanes have processed the segments, a reassembler takes their outputs back in the same rotation. The merged stream therefore leaves in the order it arrived.

A bandwidth controller drives a level input. Level L selects NUM_LANES >> L lanes, with a minimum of one. A new level is taken up only when the accepted-sample count reaches a frame boundary, so no segment or frame straddles two configurations. At that boundary the input stalls while three things happen. In-flight segments drain out of the lanes. Lanes that are joining the set are powered up early enough to settle. Lanes that are leaving are powered down. Distribution then resumes at lane 0 under the new set. The lanes themselves are outside the block. Each lane returns its samples on a per-lane valid/data pair after its own fixed latency.

Top module: `rate_lane_dist`

## Requirements
- R1: After reset, in_ready is high, every lane_pwr_en bit is high, NUM_LANES lanes are active, and lane_valid and out_valid are low.
- R2: Each run of SEG_LEN consecutive accepted samples goes to a single lane. Lanes are visited 0, 1, ..., count-1 and then back to 0. An accepted sample appears on its lane one cycle after acceptance, and at most one lane_valid bit is high in any cycle.
- R3: A lane_lvl value of L selects NUM_LANES >> L active lanes. Any value at or above log2(NUM_LANES) selects a single lane. The active lanes are always lanes 0 to count-1, and during normal running lane_pwr_en shows exactly that set.
- R4: A level change takes effect only when the number of accepted samples since reset is a multiple of FRAME_SEGS*SEG_LEN. A change requested partway through a frame does not affect that frame. in_ready is low only while a change is pending at a boundary.
- R5: The first segment after a change goes to lane 0.
- R6: out_data presents every accepted sample exactly once, in acceptance order, one cycle after the owning lane returns it.
- R7: A lane leaving the active set has lane_pwr_en deasserted only once every accepted sample has left out_data.
- R8: A lane joining the active set has lane_pwr_en high for at least WAKE_CYC cycles before its first lane_valid.
- R9: lane_valid is never high on a lane whose lane_pwr_en is low.
- R10: Idle cycles on in_valid do not advance the segment, lane or frame position, because only accepted samples count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lane_lvl | input | LVL_W | Bandwidth level; the active lane count is NUM_LANES >> lane_lvl, minimum 1 |
| in_valid | input | 1 | Input sample valid |
| in_data | input | DATA_W | Input sample |
| in_ready | output | 1 | Input can accept a sample this cycle |
| lane_valid | output | NUM_LANES | Per-lane sample strobe |
| lane_data | output | NUM_LANES*DATA_W | Per-lane sample; lane i occupies bits [i*DATA_W +: DATA_W] |
| lane_pwr_en | output | NUM_LANES | Per-lane power enable |
| ret_valid | input | NUM_LANES | Per-lane processed-sample strobe |
| ret_data | input | NUM_LANES*DATA_W | Per-lane processed sample, same packing as lane_data |
| out_valid | output | 1 | Merged output valid |
| out_data | output | DATA_W | Merged output sample |

## Verification
The bench requests level changes in the middle of a frame and checks that the stall comes only at the next frame boundary. A design that switched at once would split a frame and send a segment to the wrong lane. It grows the lane set from one lane to all lanes, and checks that each new lane was powered for the full settling time. A design that skipped the wake wait would push samples into lanes that have not yet settled. When the set shrinks, it checks that power drops only after the last sample has left the merged output. An early drop would lose data that is still in the lanes. Level values beyond the lane range, runs with idle gaps, and requests that repeat the current level are also covered, because these are the cases where the rotation pointer or the frame count could drift.

// File: rtl/rld_pkg.sv
package rld_pkg;

  typedef enum logic {ST_RUN = 1'b0, ST_PEND = 1'b1} cfg_state_e;

  // Active lane count for a bandwidth level: halve per level, floor at one.
  function automatic int unsigned lvl_to_lanes(input int unsigned lvl, input int unsigned n);
    int unsigned r;
    r = (lvl >= 32) ? 0 : (n >> lvl);
    return (r == 0) ? 1 : r;
  endfunction

  // Round-robin successor inside a set of cnt lanes.
  function automatic int unsigned rr_next(input int unsigned cur, input int unsigned cnt);
    return (cur + 1 >= cnt) ? 0 : cur + 1;
  endfunction

  // Position counter step with wrap at len.
  function automatic int unsigned wrap_inc(input int unsigned pos, input int unsigned len);
    return (pos + 1 >= len) ? 0 : pos + 1;
  endfunction

endpackage

// File: rtl/rld_split.sv
module rld_split #(
  parameter int NUM_LANES  = 4,
  parameter int DATA_W     = 16,
  parameter int SEG_LEN    = 4,
  parameter int FRAME_SEGS = 4,
  parameter int CNTL_W     = 3
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          in_fire,
  input  logic [DATA_W-1:0]             in_data,
  input  logic [CNTL_W-1:0]             cur_cnt,
  input  logic                          apply,
  output logic                          at_bound,
  output logic [NUM_LANES-1:0]          lane_valid,
  output logic [NUM_LANES*DATA_W-1:0]   lane_data
);
  import rld_pkg::*;

  localparam int LANE_W = (NUM_LANES > 1) ? $clog2(NUM_LANES) : 1;
  localparam int SEG_W  = (SEG_LEN > 1) ? $clog2(SEG_LEN) : 1;
  localparam int FRM_W  = (FRAME_SEGS > 1) ? $clog2(FRAME_SEGS) : 1;

  logic [SEG_W-1:0]  seg_pos_q;
  logic [FRM_W-1:0]  frm_seg_q;
  logic [LANE_W-1:0] wr_lane_q;
  logic [DATA_W-1:0] data_q;
  logic              seg_end;

  assign seg_end  = (int'(seg_pos_q) == SEG_LEN - 1);
  assign at_bound = (seg_pos_q == '0) && (frm_seg_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seg_pos_q  <= '0;
      frm_seg_q  <= '0;
      wr_lane_q  <= '0;
      lane_valid <= '0;
      data_q     <= '0;
    end else begin
      lane_valid <= '0;
      if (in_fire) begin
        lane_valid[wr_lane_q] <= 1'b1;
        data_q                <= in_data;
        seg_pos_q             <= SEG_W'(wrap_inc(int'(seg_pos_q), SEG_LEN));
        if (seg_end) begin
          wr_lane_q <= LANE_W'(rr_next(int'(wr_lane_q), int'(cur_cnt)));
          frm_seg_q <= FRM_W'(wrap_inc(int'(frm_seg_q), FRAME_SEGS));
        end
      end else if (apply) begin
        wr_lane_q <= '0;
      end
    end
  end

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_fan
    assign lane_data[g*DATA_W +: DATA_W] = data_q;
  end

  p_one_lane_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lane_valid));
  p_lane_in_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    in_fire |-> (int'(wr_lane_q) < int'(cur_cnt)));

endmodule

// File: rtl/rld_merge.sv
module rld_merge #(
  parameter int NUM_LANES = 4,
  parameter int DATA_W    = 16,
  parameter int SEG_LEN   = 4,
  parameter int CNTL_W    = 3
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_LANES-1:0]        ret_valid,
  input  logic [NUM_LANES*DATA_W-1:0] ret_data,
  input  logic [CNTL_W-1:0]           cur_cnt,
  input  logic                        apply,
  output logic                        out_valid,
  output logic [DATA_W-1:0]           out_data
);
  import rld_pkg::*;

  localparam int LANE_W = (NUM_LANES > 1) ? $clog2(NUM_LANES) : 1;
  localparam int SEG_W  = (SEG_LEN > 1) ? $clog2(SEG_LEN) : 1;

  logic [DATA_W-1:0]    ret_arr [NUM_LANES];
  logic [LANE_W-1:0]    rd_lane_q;
  logic [SEG_W-1:0]     rd_pos_q;
  logic [NUM_LANES-1:0] turn_sel;
  logic                 hit;

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_unpack
    assign ret_arr[g]  = ret_data[g*DATA_W +: DATA_W];
    assign turn_sel[g] = (int'(rd_lane_q) == g);
  end

  assign hit = ret_valid[rd_lane_q];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_lane_q <= '0;
      rd_pos_q  <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= hit;
      if (hit) begin
        out_data <= ret_arr[rd_lane_q];
        rd_pos_q <= SEG_W'(wrap_inc(int'(rd_pos_q), SEG_LEN));
        if (int'(rd_pos_q) == SEG_LEN - 1)
          rd_lane_q <= LANE_W'(rr_next(int'(rd_lane_q), int'(cur_cnt)));
      end else if (apply) begin
        rd_lane_q <= '0;
        rd_pos_q  <= '0;
      end
    end
  end

  // Lanes must return in the rotation order the splitter used.
  p_in_turn_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_valid & ~turn_sel) == '0);

endmodule

// File: rtl/rld_ctrl.sv
module rld_ctrl #(
  parameter int NUM_LANES = 4,
  parameter int LVL_W     = 3,
  parameter int CNTL_W    = 3,
  parameter int WAKE_CYC  = 8,
  parameter int CNT_W     = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [LVL_W-1:0]     lane_lvl,
  input  logic                 at_bound,
  input  logic                 in_fire,
  input  logic                 out_fire,
  output logic [CNTL_W-1:0]    cur_cnt,
  output logic                 apply,
  output logic                 hold,
  output logic [NUM_LANES-1:0] pwr_en
);
  import rld_pkg::*;

  localparam int WK_W = $clog2(WAKE_CYC + 1);

  cfg_state_e           state_q;
  logic [CNTL_W-1:0]    tgt_q, req_cnt;
  logic [WK_W-1:0]      wake_q;
  logic [CNT_W-1:0]     inflight_q;
  logic [NUM_LANES-1:0] mask_cur, mask_req, mask_tgt;
  logic                 start_pend, drained, grow, wake_done;

  assign req_cnt = CNTL_W'(lvl_to_lanes(int'(lane_lvl), NUM_LANES));

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_mask
    assign mask_cur[g] = (g < int'(cur_cnt));
    assign mask_req[g] = (g < int'(req_cnt));
    assign mask_tgt[g] = (g < int'(tgt_q));
  end

  assign start_pend = (state_q == ST_RUN) && at_bound && (req_cnt != cur_cnt);
  assign hold       = (state_q == ST_PEND) || start_pend;
  assign drained    = (inflight_q == '0);
  assign grow       = (tgt_q > cur_cnt);
  assign wake_done  = !grow || (wake_q == WK_W'(WAKE_CYC));
  assign apply      = (state_q == ST_PEND) && drained && wake_done;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= ST_RUN;
      cur_cnt    <= CNTL_W'(NUM_LANES);
      tgt_q      <= CNTL_W'(NUM_LANES);
      wake_q     <= '0;
      inflight_q <= '0;
      pwr_en     <= '1;
    end else begin
      if (in_fire && !out_fire)      inflight_q <= inflight_q + 1'b1;
      else if (!in_fire && out_fire) inflight_q <= inflight_q - 1'b1;
      case (state_q)
        ST_RUN: if (start_pend) begin
          state_q <= ST_PEND;
          tgt_q   <= req_cnt;
          wake_q  <= '0;
          pwr_en  <= mask_cur | mask_req;
        end
        ST_PEND: begin
          if (wake_q != WK_W'(WAKE_CYC)) wake_q <= wake_q + 1'b1;
          if (apply) begin
            state_q <= ST_RUN;
            cur_cnt <= tgt_q;
            pwr_en  <= mask_tgt;
          end
        end
        default: state_q <= ST_RUN;
      endcase
    end
  end

  p_switch_at_boundary_r4: assert property (@(posedge clk) disable iff (!rst_n)
    apply |-> at_bound);
  p_no_underflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_fire |-> (inflight_q != '0));
  for (genvar g = 0; g < NUM_LANES; g++) begin : g_pchk
    p_drop_after_drain_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pwr_en[g]) |-> $past(drained));
  end

endmodule

// File: rtl/rate_lane_dist.sv
module rate_lane_dist #(
  parameter int NUM_LANES  = 4,
  parameter int DATA_W     = 16,
  parameter int SEG_LEN    = 4,
  parameter int FRAME_SEGS = 4,
  parameter int WAKE_CYC   = 8,
  parameter int CNT_W      = 12,
  localparam int LVL_W     = ((NUM_LANES > 1) ? $clog2(NUM_LANES) : 1) + 1,
  localparam int CNTL_W    = $clog2(NUM_LANES + 1)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [LVL_W-1:0]            lane_lvl,
  input  logic                        in_valid,
  input  logic [DATA_W-1:0]           in_data,
  output logic                        in_ready,
  output logic [NUM_LANES-1:0]        lane_valid,
  output logic [NUM_LANES*DATA_W-1:0] lane_data,
  output logic [NUM_LANES-1:0]        lane_pwr_en,
  input  logic [NUM_LANES-1:0]        ret_valid,
  input  logic [NUM_LANES*DATA_W-1:0] ret_data,
  output logic                        out_valid,
  output logic [DATA_W-1:0]           out_data
);

  logic              in_fire, hold, apply, at_bound;
  logic [CNTL_W-1:0] cur_cnt;

  assign in_ready = !hold;
  assign in_fire  = in_valid && in_ready;

  rld_ctrl #(.NUM_LANES(NUM_LANES), .LVL_W(LVL_W), .CNTL_W(CNTL_W),
             .WAKE_CYC(WAKE_CYC), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .lane_lvl(lane_lvl), .at_bound(at_bound),
    .in_fire(in_fire), .out_fire(out_valid), .cur_cnt(cur_cnt),
    .apply(apply), .hold(hold), .pwr_en(lane_pwr_en));

  rld_split #(.NUM_LANES(NUM_LANES), .DATA_W(DATA_W), .SEG_LEN(SEG_LEN),
              .FRAME_SEGS(FRAME_SEGS), .CNTL_W(CNTL_W)) u_split (
    .clk(clk), .rst_n(rst_n), .in_fire(in_fire), .in_data(in_data),
    .cur_cnt(cur_cnt), .apply(apply), .at_bound(at_bound),
    .lane_valid(lane_valid), .lane_data(lane_data));

  rld_merge #(.NUM_LANES(NUM_LANES), .DATA_W(DATA_W), .SEG_LEN(SEG_LEN),
              .CNTL_W(CNTL_W)) u_merge (
    .clk(clk), .rst_n(rst_n), .ret_valid(ret_valid), .ret_data(ret_data),
    .cur_cnt(cur_cnt), .apply(apply), .out_valid(out_valid), .out_data(out_data));

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_pwr_chk
    p_powered_use_r9: assert property (@(posedge clk) disable iff (!rst_n)
      lane_valid[g] |-> lane_pwr_en[g]);
  end

endmodule

// File: tb/tb_rate_lane_dist.sv
module tb_rate_lane_dist;
  localparam int N     = 4;
  localparam int DW    = 16;
  localparam int SEG   = 4;
  localparam int FSEGS = 4;
  localparam int FLEN  = SEG * FSEGS;
  localparam int WAKE  = 8;
  localparam int LAT   = 3;
  localparam int NPH   = 8;

  // Phase vectors: requested level, samples, idle gap, expected lane count.
  localparam int PH_LVL [NPH] = '{0, 1, 2, 0, 5, 1, 1, 0};
  localparam int PH_N   [NPH] = '{40, 37, 30, 50, 20, 33, 10, 25};
  localparam int PH_GAP [NPH] = '{0, 0, 1, 0, 2, 0, 0, 1};
  localparam int PH_CNT [NPH] = '{4, 2, 1, 4, 1, 2, 2, 4};

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [2:0]    lane_lvl = '0;
  logic          in_valid = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic          in_ready;
  logic [N-1:0]  lane_valid, lane_pwr_en, ret_valid;
  logic [N*DW-1:0] lane_data, ret_data;
  logic          out_valid;
  logic [DW-1:0] out_data;

  always #10 clk = ~clk;

  rate_lane_dist #(.NUM_LANES(N), .DATA_W(DW), .SEG_LEN(SEG),
                   .FRAME_SEGS(FSEGS), .WAKE_CYC(WAKE)) dut (
    .clk(clk), .rst_n(rst_n), .lane_lvl(lane_lvl), .in_valid(in_valid),
    .in_data(in_data), .in_ready(in_ready), .lane_valid(lane_valid),
    .lane_data(lane_data), .lane_pwr_en(lane_pwr_en), .ret_valid(ret_valid),
    .ret_data(ret_data), .out_valid(out_valid), .out_data(out_data));

  // Lane model: fixed-latency pass-through.
  logic [N-1:0]    vpipe [LAT];
  logic [N*DW-1:0] dpipe [LAT];
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < LAT; i++) begin vpipe[i] <= '0; dpipe[i] <= '0; end
    end else begin
      vpipe[0] <= lane_valid; dpipe[0] <= lane_data;
      for (int i = 1; i < LAT; i++) begin vpipe[i] <= vpipe[i-1]; dpipe[i] <= dpipe[i-1]; end
    end
  end
  assign ret_valid = vpipe[LAT-1];
  assign ret_data  = dpipe[LAT-1];

  int n_chk = 0, n_bad = 0;
  int acc = 0, exp_out = 0, mcur = N, kseg = 0, cyc = 0;
  int pcnt [N];
  logic [N-1:0] prev_pwr = '1;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  function automatic int count_of(input int lvl);
    int c = N;
    for (int i = 0; i < lvl; i++) if (c > 1) c = c / 2;
    return c;
  endfunction

  function automatic int mask_of(input int c);
    return (1 << c) - 1;
  endfunction

  always @(negedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) pcnt[i] = 1000;
      prev_pwr = '1;
    end else begin
      cyc++;
      if (cyc > 50000) begin
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 50000);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
      end
      if (out_valid) begin
        chk(out_data == DW'(exp_out), "R6", int'(out_data), exp_out);
        exp_out++;
      end
      for (int i = 0; i < N; i++) begin
        if (lane_pwr_en[i]) pcnt[i]++; else pcnt[i] = 0;
        if (lane_valid[i]) begin
          chk(lane_pwr_en[i], "R9", int'(lane_pwr_en[i]), 1);
          chk(pcnt[i] > WAKE, "R8", pcnt[i] - 1, WAKE);
        end
        if (prev_pwr[i] && !lane_pwr_en[i])
          chk(acc == exp_out, "R7", acc - exp_out, 0);
      end
      prev_pwr = lane_pwr_en;
    end
  end

  task automatic push(input int lvl, input string req);
    int stalls = 0;
    int lane;
    bit changed = 0;
    in_valid = 1'b1;
    in_data  = DW'(acc);
    forever begin
      #1;
      if (in_ready) break;
      stalls++;
      if (stalls == 1) chk((acc % FLEN) == 0, "R4", acc % FLEN, 0);
      @(negedge clk);
    end
    if ((acc % FLEN) == 0 && count_of(lvl) != mcur) begin
      mcur = count_of(lvl); kseg = 0; changed = 1;
    end
    chk(changed ? (stalls > 0) : (stalls == 0), "R4", stalls, changed ? 1 : 0);
    chk(lane_pwr_en == N'(mask_of(mcur)), "R3", int'(lane_pwr_en), mask_of(mcur));
    lane = (kseg / SEG) % mcur;
    kseg++; acc++;
    @(negedge clk);
    in_valid = 1'b0;
    chk(lane_valid == N'(1 << lane), changed ? "R5" : req, int'(lane_valid), 1 << lane);
    chk(lane_data[lane*DW +: DW] == DW'(acc - 1), req, int'(lane_data[lane*DW +: DW]), acc - 1);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    // R1: reset state
    #1;
    chk(in_ready == 1'b1, "R1", int'(in_ready), 1);
    chk(lane_pwr_en == '1, "R1", int'(lane_pwr_en), mask_of(N));
    chk(lane_valid == '0 && out_valid == 1'b0, "R1", int'(lane_valid), 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    for (int p = 0; p < NPH; p++) begin
      lane_lvl = 3'(PH_LVL[p]);
      for (int s = 0; s < PH_N[p]; s++) begin
        push(PH_LVL[p], (PH_GAP[p] > 0) ? "R10" : "R2");
        repeat (PH_GAP[p]) @(negedge clk);
      end
      // R3: lane count from level, including clamp beyond range
      chk(mcur == PH_CNT[p], "R3", mcur, PH_CNT[p]);
    end
    // Idle at a non-boundary with a change request: nothing may move (R4, R10)
    lane_lvl = 3'd2;
    repeat (30) @(negedge clk);
    #1;
    if ((acc % FLEN) != 0) begin
      chk(in_ready == 1'b1, "R4", int'(in_ready), 1);
      chk(lane_pwr_en == N'(mask_of(mcur)), "R4", int'(lane_pwr_en), mask_of(mcur));
    end
    // R6: every accepted sample came out
    chk(exp_out == acc, "R6", exp_out, acc);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule